// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose read and write commands share one fixed pipeline, so a new command of either type can be accepted on every clock with no idle cycle between a write and a following read. The data word is two 9-bit bytes (18 bits). Commands are issued with active-low controls: a load strobe that starts a new access, a chip enable, a write enable and one write enable per byte. A command issued with the load strobe high continues the running burst, stepping a 2-bit counter through four locations.

Write data follows its command by two enabled clock cycles, and read data comes out of a registered output two enabled clock edges after its command, with a valid flag. A high clock enable freezes every register in the block, as if the edge had not happened. The block sits behind a memory controller that separates the input and output data buses; there are no bidirectional pads.

Top module: `pzt_sram`

## Requirements
- R1: While rst_n is low at a rising edge, dout becomes 0 and dout_vld becomes 0.
- R2: A load-read (cke_n, adv_n, ce_n low, we_n high) at edge E drives dout with the word stored at addr and dout_vld high after the second enabled edge following E.
- R3: A load-write (cke_n, adv_n, ce_n, we_n low) stores the din value presented two enabled cycles after the command cycle; dout_vld is low in that command's output slot.
- R4: bw_n is sampled in the write command cycle; bw_n[0] low enables din[8:0] and bw_n[1] low enables din[17:9]; a high bit leaves that byte of the word unchanged.
- R5: On read commands bw_n has no effect: memory contents and returned data are unchanged by it.
- R6: With adv_n high after a load, each enabled cycle issues the same command type at the address whose upper bits equal the loaded address and whose two low bits are the previous low bits plus one, modulo 4.
- R7: A load with ce_n high issues no operation, makes dout_vld low in its output slot, and later continuation cycles also issue nothing until the next load.
- R8: When cke_n is high at an edge, all other inputs are ignored and dout and dout_vld keep their values.
- R9: A read of an address in the cycle right after a write to that address returns the newly written data.
- R10: While dout_vld is low, dout holds the last read value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| ce_n | input | 1 | Chip enable, active low, sampled on load cycles |
| we_n | input | 1 | Write enable, active low, sampled on load cycles |
| adv_n | input | 1 | Low loads a new command, high continues the burst |
| bw_n | input | NB | Per-byte write enables, active low |
| addr | input | AW | Word address, sampled on load cycles |
| din | input | NB*BYTE_W | Write data, presented two cycles after its command |
| dout | output | NB*BYTE_W | Registered read data |
| dout_vld | output | 1 | High when dout carries data for a read command |

## Verification
The collision of interest is a write's late data commit and a read's array access falling on neighbouring pipeline slots of the same address, and in the frozen case a clock-enable stall landing in the middle of that overlap. The bench provokes it by alternating write and read commands to every address with no gap, with and without stall cycles inserted between them, and by burst writes immediately followed by wrapping burst reads. Every cycle the outputs are compared against a bench model built from the requirements, whose memory is updated by byte masks computed arithmetically.

// File: rtl/pzt_pkg.sv
// Shared definitions for the pipelined zero-turnaround SRAM.
// Assumes: commands are one of three kinds and travel through the pipeline unchanged.
package pzt_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;
endpackage

// File: rtl/pzt_burst_ctrl.sv
// Command decoder and burst sequencer.
// Turns the control inputs of one cycle into a command (kind, address, byte mask).
// Assumes: AW >= 3; the low two address bits form the burst counter.
module pzt_burst_ctrl
    import pzt_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          adv_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [NB-1:0] bw_n,
    input  logic [AW-1:0] addr,
    output op_e           iss_op,
    output logic [AW-1:0] iss_addr,
    output logic [NB-1:0] iss_bw_n
);
    localparam int HI_W = AW - 2;

    logic            active_q;
    logic            wr_q;
    logic [HI_W-1:0] base_hi_q;
    logic [1:0]      cnt_q;
    logic [1:0]      cnt_nx;

    assign cnt_nx = cnt_q + 2'd1;

    // Decode the command issued in this cycle.
    always_comb begin
        iss_op   = OP_NOP;
        iss_addr = addr;
        if (!adv_n) begin
            if (!ce_n) iss_op = we_n ? OP_RD : OP_WR;
        end else if (active_q) begin
            iss_op   = wr_q ? OP_WR : OP_RD;
            iss_addr = {base_hi_q, cnt_nx};
        end
        iss_bw_n = (iss_op == OP_WR) ? bw_n : '1;
    end

    // Hold burst state: loaded on load cycles, stepped on continuations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            wr_q      <= 1'b0;
            base_hi_q <= '0;
            cnt_q     <= '0;
        end else if (en) begin
            if (!adv_n) begin
                active_q  <= !ce_n;
                wr_q      <= !we_n;
                base_hi_q <= addr[AW-1:2];
                cnt_q     <= addr[1:0];
            end else if (active_q) begin
                cnt_q <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/pzt_pipe.sv
// Fixed-latency command pipeline.
// Carries each issued command LAT enabled cycles before it reaches the array.
// Assumes: LAT >= 1; a frozen cycle (en low) moves nothing.
module pzt_pipe
    import pzt_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NB  = 2,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  op_e           in_op,
    input  logic [AW-1:0] in_addr,
    input  logic [NB-1:0] in_bw_n,
    output op_e           out_op,
    output logic [AW-1:0] out_addr,
    output logic [NB-1:0] out_bw_n
);
    op_e           op_q   [LAT];
    logic [AW-1:0] addr_q [LAT];
    logic [NB-1:0] bw_q   [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            // First slot captures the freshly issued command.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    op_q[s]   <= OP_NOP;
                    addr_q[s] <= '0;
                    bw_q[s]   <= '1;
                end else if (en) begin
                    op_q[s]   <= in_op;
                    addr_q[s] <= in_addr;
                    bw_q[s]   <= in_bw_n;
                end
            end
        end else begin : g_body
            // Later slots shift the command one step further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    op_q[s]   <= OP_NOP;
                    addr_q[s] <= '0;
                    bw_q[s]   <= '1;
                end else if (en) begin
                    op_q[s]   <= op_q[s-1];
                    addr_q[s] <= addr_q[s-1];
                    bw_q[s]   <= bw_q[s-1];
                end
            end
        end
    end

    assign out_op   = op_q[LAT-1];
    assign out_addr = addr_q[LAT-1];
    assign out_bw_n = bw_q[LAT-1];
endmodule

// File: rtl/pzt_store.sv
// Byte-banked storage array with a registered read port.
// Executes the command leaving the pipeline: commits masked write data or loads dout.
// Assumes: one command per enabled edge, so a read and a write never share an edge.
module pzt_store
    import pzt_pkg::*;
#(
    parameter int AW     = 6,
    parameter int NB     = 2,
    parameter int BYTE_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  op_e                  op,
    input  logic [AW-1:0]        addr,
    input  logic [NB-1:0]        bw_n,
    input  logic [NB*BYTE_W-1:0] din,
    output logic [NB*BYTE_W-1:0] dout,
    output logic                 dout_vld
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * BYTE_W;

    logic [DW-1:0] rd_word;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [BYTE_W-1:0] bank [DEPTH];

        // Commit this byte lane when the write mask selects it.
        always_ff @(posedge clk) begin
            if (en && op == OP_WR && !bw_n[b]) begin
                bank[addr] <= din[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_word[b*BYTE_W +: BYTE_W] = bank[addr];
    end

    // Register read data and its valid flag; dout holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else if (en) begin
            dout_vld <= (op == OP_RD);
            if (op == OP_RD) dout <= rd_word;
        end
    end
endmodule

// File: rtl/pzt_sram.sv
// Top of the pipelined zero-turnaround SRAM.
// Decodes commands, delays them two enabled cycles, then runs them on the array.
// Assumes: cke_n low marks a normal edge; cke_n high freezes every register.
module pzt_sram
    import pzt_pkg::*;
#(
    parameter int AW     = 6,
    parameter int NB     = 2,
    parameter int BYTE_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke_n,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic                 adv_n,
    input  logic [NB-1:0]        bw_n,
    input  logic [AW-1:0]        addr,
    input  logic [NB*BYTE_W-1:0] din,
    output logic [NB*BYTE_W-1:0] dout,
    output logic                 dout_vld
);
    localparam int LAT = 2;

    logic          en;
    op_e           iss_op;
    logic [AW-1:0] iss_addr;
    logic [NB-1:0] iss_bw_n;
    op_e           exe_op;
    logic [AW-1:0] exe_addr;
    logic [NB-1:0] exe_bw_n;

    assign en = !cke_n;

    pzt_burst_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .adv_n    (adv_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .addr     (addr),
        .iss_op   (iss_op),
        .iss_addr (iss_addr),
        .iss_bw_n (iss_bw_n)
    );

    pzt_pipe #(.AW(AW), .NB(NB), .LAT(LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_op    (iss_op),
        .in_addr  (iss_addr),
        .in_bw_n  (iss_bw_n),
        .out_op   (exe_op),
        .out_addr (exe_addr),
        .out_bw_n (exe_bw_n)
    );

    pzt_store #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .op       (exe_op),
        .addr     (exe_addr),
        .bw_n     (exe_bw_n),
        .din      (din),
        .dout     (dout),
        .dout_vld (dout_vld)
    );
endmodule

// File: rtl/pzt_sram_chk.sv
// Port-level checker for pzt_sram, attached with bind.
// Tracks load commands seen at the ports two enabled cycles back and checks the output slot.
module pzt_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          adv_n,
    input logic [DW-1:0] dout,
    input logic          dout_vld
);
    logic [1:0] ld_rd_q;
    logic [1:0] ld_wr_q;
    logic [1:0] ld_ds_q;

    // Shift port-observed load kinds along with enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_rd_q <= '0;
            ld_wr_q <= '0;
            ld_ds_q <= '0;
        end else if (!cke_n) begin
            ld_rd_q <= {ld_rd_q[0], !adv_n && !ce_n && we_n};
            ld_wr_q <= {ld_wr_q[0], !adv_n && !ce_n && !we_n};
            ld_ds_q <= {ld_ds_q[0], !adv_n && ce_n};
        end
    end

    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_rd_q[1]) |=> dout_vld);

    a_r3_write_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_wr_q[1]) |=> !dout_vld);

    a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_ds_q[1]) |=> !dout_vld);

    a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dout) && $stable(dout_vld)));

    a_r10_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> $stable(dout));
endmodule

bind pzt_sram pzt_sram_chk #(.DW(NB * BYTE_W)) u_chk (.*);

// File: tb/test_pzt_sram.sv
`timescale 1ns/1ps
module test_pzt_sram;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b1;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          adv_n = 1'b0;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld;

    always #2 clk = ~clk;

    pzt_sram #(.AW(AW), .NB(NB), .BYTE_W(BW)) i_pzt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce_n(ce_n), .we_n(we_n),
        .adv_n(adv_n), .bw_n(bw_n), .addr(addr), .din(din),
        .dout(dout), .dout_vld(dout_vld)
    );

    int n_vec = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 0;

    // Reference model state (0 nop, 1 read, 2 write).
    logic [DW-1:0] mm [DEPTH];
    int            pk [2];
    logic [AW-1:0] pa [2];
    logic [NB-1:0] pb [2];
    bit            m_act = 0;
    bit            m_wr = 0;
    logic [AW-1:0] m_base = '0;
    logic [DW-1:0] e_dout = '0;
    bit            e_vld = 0;
    logic [DW-1:0] seed = 18'h1a5;

    task automatic check_out();
        n_vec++;
        if (dout_vld !== e_vld || dout !== e_dout) begin
            n_bad++;
            $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b",
                     tag, dout, dout_vld, e_dout, e_vld);
        end
    endtask

    task automatic step(input logic k, input logic w, input logic v,
                        input logic c, input logic [NB-1:0] b,
                        input logic [AW-1:0] a);
        int            kind;
        logic [AW-1:0] ea;
        @(negedge clk);
        seed  = seed * 18'd97 + 18'd1013;
        cke_n = k; we_n = w; adv_n = v; ce_n = c; bw_n = b; addr = a; din = seed;
        @(posedge clk);
        if (rst_n && !k) begin
            if (pk[1] == 2) begin
                for (int i = 0; i < NB; i++)
                    if (!pb[1][i]) mm[pa[1]][i*BW +: BW] = din[i*BW +: BW];
            end
            if (pk[1] == 1) begin
                e_dout = mm[pa[1]];
                e_vld  = 1;
            end else begin
                e_vld = 0;
            end
            kind = 0;
            ea   = a;
            if (!v) begin
                if (!c) kind = w ? 1 : 2;
                m_act  = !c;
                m_wr   = !w;
                m_base = a;
            end else if (m_act) begin
                kind   = m_wr ? 2 : 1;
                m_base = {m_base[AW-1:2], m_base[1:0] + 2'd1};
                ea     = m_base;
            end
            pk[1] = pk[0]; pa[1] = pa[0]; pb[1] = pb[0];
            pk[0] = kind;  pa[0] = ea;    pb[0] = b;
        end
        #1;
        check_out();
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, '1, '0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    initial begin
        pk[0] = 0; pk[1] = 0; pa[0] = '0; pa[1] = '0; pb[0] = '1; pb[1] = '1;
        // R1: reset state, with random inputs during reset.
        tag = "R1";
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 2'b00, AW'(i));
        rst_n = 1'b1;
        step(1, 1, 0, 1, '1, '0);

        // R3 R6: fill every word with burst writes.
        tag = "R3 R6";
        for (int s = 0; s < DEPTH; s += 4) begin
            step(0, 0, 0, 0, 2'b00, AW'(s + 1));
            for (int j = 0; j < 3; j++) step(0, 1, 1, 1, 2'b00, '0);
        end
        flush();

        // R2 R6: wrapping burst reads from every start address.
        tag = "R2 R6";
        for (int s = 0; s < DEPTH; s++) begin
            step(0, 1, 0, 0, 2'b11, AW'(s));
            for (int j = 0; j < 3; j++) step(0, 0, 1, 1, 2'b00, AW'(j));
        end
        flush();

        // R4: every byte-mask value on each address, then read back.
        tag = "R4";
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 0, 2'(m), AW'(a));
        flush();
        for (int a = 0; a < DEPTH; a++) step(0, 1, 0, 0, 2'b11, AW'(a));
        flush();

        // R5: reads with byte enables low, then confirm contents unchanged.
        tag = "R5";
        for (int a = 0; a < DEPTH; a++) step(0, 1, 0, 0, 2'b00, AW'(a));
        for (int a = 0; a < DEPTH; a++) step(0, 1, 0, 0, 2'b01, AW'(a));
        flush();

        // R9: write then immediate read of the same address.
        tag = "R9";
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 0, 0, 0, 2'b00, AW'(a));
            step(0, 1, 0, 0, 2'b11, AW'(a));
        end
        flush();

        // R8: stall cycles with random inputs inside write/read traffic.
        tag = "R8 R9";
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 0, 0, 0, 2'(a), AW'(a));
            step(1, 0, 0, 0, 2'b00, AW'(a + 3));
            step(0, 1, 0, 0, 2'b11, AW'(a));
            step(1, 1, 0, 0, 2'b00, AW'(a + 5));
            step(0, 0, 1, 0, 2'b10, AW'(a));
        end
        flush();
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 1, 0, 0, 2'b11, AW'(a));
            step(1, 0, 0, 0, 2'b00, AW'(a + 7));
        end
        flush();

        // R7 R10: deselect, then continuations must stay silent, dout held.
        tag = "R7 R10";
        step(0, 1, 0, 0, 2'b11, AW'(6));
        step(0, 1, 0, 1, 2'b00, AW'(9));
        for (int j = 0; j < 6; j++) step(0, j[0], 1, 0, 2'b00, AW'(j));
        step(0, 0, 0, 1, 2'b00, AW'(2));
        for (int j = 0; j < 4; j++) step(0, 1, 1, 0, 2'b00, AW'(j));
        flush();

        summary();
    end
endmodule